// File: doc/BRIEF.md
# Three-Channel Shared-Clock SSI Position Reader

This block is a synchronous-serial master that reads three absolute rotary encoders over one common clock line. The encoders all see the same falling edge at the start of a frame, so the three positions they report belong to one moment in time. This matters when the positions feed a motor control loop that expects a coherent snapshot. There is no select line. A frame is marked only by clock activity: the line rests high, a start request pulls it low, and a burst of low/high half-periods follows. The system clock divider parameter sets the length of each half-period.

After every rising edge of the serial clock, the block waits out the high half-period. At the end of it, all three data inputs are sampled in the same system cycle and shifted, most significant bit first, into three separate shift registers. Once the configured number of bits has arrived, the three position words are loaded together and a one-cycle valid pulse is raised. The serial clock then stays high for a recovery gap so the encoders can release their latched value. A busy flag covers the whole frame and the gap, and start requests are ignored while it is set.

Top module: `ssi_tri_reader`

## Requirements
- R1: While reset is held, and directly after it, the serial clock output is high, busy and valid are low, and every position word is zero.
- R2: A start request sampled while busy is low makes the serial clock fall and busy rise on the next system clock edge.
- R3: Every low and every high half-period of a frame lasts exactly HALF_DIV system cycles, and a frame contains exactly FRAME_BITS rising serial clock edges.
- R4: Each channel's data input is sampled in the last system cycle of each high half-period. The first sampled bit becomes bit FRAME_BITS-1 (MSB) of the position word and the last sampled bit becomes bit 0.
- R5: All position words are updated together on the system edge that takes the final sample. Valid is high for exactly that one cycle, 2*HALF_DIV*FRAME_BITS cycles after the start edge, and the position words hold their value at all other times.
- R6: After the final sample the serial clock stays high and busy stays high for GAP_CYCLES system cycles. Busy then falls.
- R7: A start request seen while busy is high has no effect: the current frame's length, edge count and gap are unchanged, and no new frame follows.
- R8: Channel k of the position output (bits k*FRAME_BITS and up) is built only from data input bit k.
- R9: Whenever busy is low, the serial clock output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to read one frame; acted on only when idle |
| sclk_o | output | 1 | Shared serial clock to all encoders, idles high |
| data_i | input | N_CH | Serial data line of each encoder, bit k for channel k |
| busy_o | output | 1 | High from frame start through the end of the recovery gap |
| valid_o | output | 1 | One-cycle pulse when new position words are presented |
| pos_o | output | N_CH*FRAME_BITS | Packed position words, channel k in bits k*FRAME_BITS +: FRAME_BITS |

## Verification
The serial clock falls and busy rises one system edge after the start request is sampled. Valid and the new position words appear 2*HALF_DIV*FRAME_BITS edges after that start edge, and busy falls GAP_CYCLES edges later still. The bench drives inputs on the falling system edge and counts falling edges from the start edge, so each result is compared at exactly its due index and not merely at some later point. Start requests placed in the first cycle, mid-frame and in the last gap cycle must leave these indices and the counted rising serial edges unchanged.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    // Sequencer states: rest, serial clock low, serial clock high, recovery gap.
    typedef enum logic [1:0] {
        SSI_IDLE = 2'd0,
        SSI_LOW  = 2'd1,
        SSI_HIGH = 2'd2,
        SSI_GAP  = 2'd3
    } ssi_state_e;

    // Strobes from the sequencer to the per-channel shifters.
    typedef struct packed {
        logic sample;   // take one bit from every data line
        logic last;     // this sample completes the frame
    } ssi_strobe_t;

    localparam int unsigned SSI_MIN_BITS = 8;
    localparam int unsigned SSI_MAX_BITS = 32;

    // Counter width able to hold values 0 .. n-1.
    function automatic int unsigned ctr_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ssi_phase_timer.sv
module ssi_phase_timer
    import ssi_pkg::*;
#(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int unsigned W = ctr_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Done marks the final cycle of a LIMIT-cycle interval; the count wraps there.
    assign done = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssi_seq_fsm.sv
module ssi_seq_fsm
    import ssi_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned HALF_DIV   = 25,
    parameter int unsigned GAP_CYCLES = 5000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    output logic        sclk_o,
    output logic        busy_o,
    output logic        valid_o,
    output ssi_strobe_t strobe_o
);
    localparam int unsigned BW = ctr_width(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    ssi_state_e    state_q;
    logic          sclk_q;
    logic          valid_q;
    logic [BW-1:0] bit_q;

    logic half_en, half_done;
    logic gap_en, gap_done;
    logic tmr_clr;

    assign half_en = (state_q == SSI_LOW) || (state_q == SSI_HIGH);
    assign gap_en  = (state_q == SSI_GAP);
    assign tmr_clr = (state_q == SSI_IDLE);

    ssi_phase_timer #(.LIMIT(HALF_DIV)) half_tmr_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .en   (half_en),
        .done (half_done)
    );

    ssi_phase_timer #(.LIMIT(GAP_CYCLES)) gap_tmr_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .en   (gap_en),
        .done (gap_done)
    );

    // Sampling happens as the high half-period runs out, well after the rising edge.
    always_comb begin
        strobe_o.sample = (state_q == SSI_HIGH) && half_done;
        strobe_o.last   = strobe_o.sample && (bit_q == LAST_BIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SSI_IDLE;
            sclk_q  <= 1'b1;
            valid_q <= 1'b0;
            bit_q   <= '0;
        end else begin
            valid_q <= strobe_o.last;
            unique case (state_q)
                SSI_IDLE: begin
                    if (start_i) begin
                        // Falling edge makes every encoder freeze its position.
                        state_q <= SSI_LOW;
                        sclk_q  <= 1'b0;
                        bit_q   <= '0;
                    end
                end
                SSI_LOW: begin
                    if (half_done) begin
                        state_q <= SSI_HIGH;
                        sclk_q  <= 1'b1;
                    end
                end
                SSI_HIGH: begin
                    if (half_done) begin
                        if (bit_q == LAST_BIT) begin
                            state_q <= SSI_GAP;
                        end else begin
                            state_q <= SSI_LOW;
                            sclk_q  <= 1'b0;
                            bit_q   <= bit_q + 1'b1;
                        end
                    end
                end
                SSI_GAP: begin
                    if (gap_done) begin
                        state_q <= SSI_IDLE;
                    end
                end
                default: begin
                    state_q <= SSI_IDLE;
                    sclk_q  <= 1'b1;
                end
            endcase
        end
    end

    assign sclk_o  = sclk_q;
    assign busy_o  = (state_q != SSI_IDLE);
    assign valid_o = valid_q;
endmodule

// File: rtl/ssi_shift_chan.sv
module ssi_shift_chan
    import ssi_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  din,
    input  ssi_strobe_t           strobe,
    output logic [FRAME_BITS-1:0] pos_o
);
    logic [FRAME_BITS-1:0] sr_q;
    logic [FRAME_BITS-1:0] sr_next;
    logic [FRAME_BITS-1:0] pos_q;

    // Earlier bits move toward the MSB as new ones enter at bit 0.
    assign sr_next = {sr_q[FRAME_BITS-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            pos_q <= '0;
        end else if (strobe.sample) begin
            sr_q <= sr_next;
            if (strobe.last) begin
                pos_q <= sr_next;
            end
        end
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/ssi_tri_reader.sv
module ssi_tri_reader
    import ssi_pkg::*;
#(
    parameter int unsigned N_CH       = 3,
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned HALF_DIV   = 25,
    parameter int unsigned GAP_CYCLES = 5000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    output logic                       sclk_o,
    input  logic [N_CH-1:0]            data_i,
    output logic                       busy_o,
    output logic                       valid_o,
    output logic [N_CH*FRAME_BITS-1:0] pos_o
);
    localparam int unsigned POS_W = N_CH * FRAME_BITS;

    ssi_strobe_t strobe;

    ssi_seq_fsm #(
        .FRAME_BITS (FRAME_BITS),
        .HALF_DIV   (HALF_DIV),
        .GAP_CYCLES (GAP_CYCLES)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .sclk_o   (sclk_o),
        .busy_o   (busy_o),
        .valid_o  (valid_o),
        .strobe_o (strobe)
    );

    logic [POS_W-1:0] pos_all;

    // One shifter per encoder, all driven by the same strobe.
    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        ssi_shift_chan #(.FRAME_BITS(FRAME_BITS)) chan_i (
            .clk    (clk),
            .rst    (rst),
            .din    (data_i[c]),
            .strobe (strobe),
            .pos_o  (pos_all[c*FRAME_BITS +: FRAME_BITS])
        );
    end

    assign pos_o = pos_all;
endmodule

// File: rtl/ssi_tri_reader_chk.sv
module ssi_tri_reader_chk #(
    parameter int unsigned N_CH       = 3,
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned HALF_DIV   = 25,
    parameter int unsigned GAP_CYCLES = 5000
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start_i,
    input logic                       sclk_o,
    input logic                       busy_o,
    input logic                       valid_o,
    input logic [N_CH*FRAME_BITS-1:0] pos_o
);
    logic [31:0] low_len;
    logic [31:0] high_len;
    logic [31:0] gap_len;
    logic        rise_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_len   <= '0;
            high_len  <= '0;
            gap_len   <= '0;
            rise_seen <= 1'b0;
        end else begin
            low_len   <= sclk_o ? 32'd0 : low_len + 32'd1;
            high_len  <= sclk_o ? high_len + 32'd1 : 32'd0;
            gap_len   <= valid_o ? 32'd1 : gap_len + 32'd1;
            rise_seen <= !busy_o ? 1'b0 : (sclk_o ? 1'b1 : rise_seen);
        end
    end

    assert_start_drops_clock_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !sclk_o));

    assert_low_half_len_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> (low_len == HALF_DIV));

    assert_high_half_len_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk_o) && rise_seen) |-> (high_len == HALF_DIV));

    assert_valid_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_pos_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(pos_o));

    assert_valid_in_gap_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (busy_o && sclk_o));

    assert_gap_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (gap_len == GAP_CYCLES));

    assert_idle_clock_high_R9: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> sclk_o);
endmodule

bind ssi_tri_reader ssi_tri_reader_chk #(
    .N_CH       (N_CH),
    .FRAME_BITS (FRAME_BITS),
    .HALF_DIV   (HALF_DIV),
    .GAP_CYCLES (GAP_CYCLES)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .sclk_o  (sclk_o),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .pos_o   (pos_o)
);

// File: tb/ssi_tri_reader_tb.sv
module ssi_tri_reader_tb_top;
    localparam int N  = 3;
    localparam int F  = 16;
    localparam int H  = 3;
    localparam int G  = 24;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [N-1:0]   data_i = '1;
    logic           sclk_o, busy_o, valid_o;
    logic [N*F-1:0] pos_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [F-1:0] enc_word [N];
    int  rise_cnt = 0;
    bit  frame_active = 0;

    always #2 clk = ~clk;  // 250 MHz

    ssi_tri_reader #(
        .N_CH(N), .FRAME_BITS(F), .HALF_DIV(H), .GAP_CYCLES(G)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .sclk_o(sclk_o),
        .data_i(data_i), .busy_o(busy_o), .valid_o(valid_o), .pos_o(pos_o)
    );

    // Encoder model: after each rising serial edge, present the next bit, MSB first.
    always @(posedge sclk_o) begin
        if (frame_active && rise_cnt < F) begin
            for (int c = 0; c < N; c++) data_i[c] <= enc_word[c][F-1-rise_cnt];
        end
        rise_cnt = rise_cnt + 1;
    end

    function automatic int valid_due();
        return 2 * H * F;
    endfunction

    function automatic int idle_due();
        return 2 * H * F + G;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One frame; inj >= 0 raises start for one cycle after that observation index.
    task automatic run_frame(input int inj);
        int n, got_valid, n_valid, busy_end, sclk_low_gap;
        logic [F-1:0] cap [N];
        rise_cnt = 0;
        frame_active = 1;
        data_i = '1;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(!sclk_o && busy_o, "R2", {30'd0, sclk_o, busy_o}, 32'h1);
        n = 0; got_valid = -1; n_valid = 0; busy_end = -1; sclk_low_gap = 0;
        start_i = (inj == 0);
        while (n < idle_due() + 5) begin
            @(negedge clk);
            n++;
            if (valid_o) begin
                n_valid++;
                if (got_valid < 0) begin
                    got_valid = n;
                    for (int c = 0; c < N; c++) cap[c] = pos_o[c*F +: F];
                end
            end
            if (got_valid >= 0 && busy_end < 0 && !sclk_o) sclk_low_gap++;
            if (busy_end < 0 && !busy_o) busy_end = n;
            start_i = (n == inj);
        end
        start_i = 1'b0;
        frame_active = 0;
        check(got_valid == valid_due(), "R5", 32'(got_valid), 32'(valid_due()));
        check(n_valid == 1, "R5", 32'(n_valid), 32'd1);
        check(rise_cnt == F, "R3", 32'(rise_cnt), 32'(F));
        for (int c = 0; c < N; c++)
            check(cap[c] == enc_word[c], (c == 0) ? "R4" : "R8",
                  32'(cap[c]), 32'(enc_word[c]));
        check(busy_end == idle_due(), "R6", 32'(busy_end), 32'(idle_due()));
        check(sclk_low_gap == 0, "R6", 32'(sclk_low_gap), 32'd0);
        check(sclk_o && !busy_o, (inj >= 0) ? "R7" : "R9",
              {30'd0, sclk_o, busy_o}, 32'h2);
    endtask

    initial begin
        void'($urandom(32'h5a17c3));
        for (int c = 0; c < N; c++) enc_word[c] = '0;
        repeat (4) @(negedge clk);
        check(sclk_o && !busy_o && !valid_o, "R1", {29'd0, sclk_o, busy_o, valid_o}, 32'h4);
        check(pos_o == '0, "R1", 32'(pos_o[F-1:0]), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(sclk_o && !busy_o && pos_o == '0, "R1", {30'd0, sclk_o, busy_o}, 32'h2);

        // Directed: all ones, all zeros, distinct per-channel patterns (R8).
        for (int c = 0; c < N; c++) enc_word[c] = '1;
        run_frame(-1);
        for (int c = 0; c < N; c++) enc_word[c] = '0;
        run_frame(-1);
        enc_word[0] = {1'b1, {(F-1){1'b0}}};
        enc_word[1] = {{(F-1){1'b0}}, 1'b1};
        enc_word[2] = {(F/2){2'b10}};
        run_frame(-1);

        // R7: start during the first cycle, mid-frame, and in the last gap cycle.
        enc_word[0] = 16'h1234; enc_word[1] = 16'hbeef; enc_word[2] = 16'h0f0f;
        run_frame(0);
        run_frame(valid_due() / 2);
        run_frame(idle_due() - 1);

        // Idle hold: toggling data and no start leaves the outputs untouched (R5, R9).
        begin
            logic [N*F-1:0] held;
            held = pos_o;
            for (int i = 0; i < 20; i++) begin
                data_i = N'($urandom);
                @(negedge clk);
                check(pos_o == held && !valid_o, "R5", 32'(pos_o[F-1:0]), 32'(held[F-1:0]));
                check(sclk_o && !busy_o, "R9", {30'd0, sclk_o, busy_o}, 32'h2);
            end
        end

        // Random frames, some with a stray start while busy.
        for (int k = 0; k < 14; k++) begin
            for (int c = 0; c < N; c++) enc_word[c] = F'($urandom);
            run_frame(($urandom % 2) ? int'($urandom % idle_due()) : -1);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL all: watchdog expired, actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule